// File: doc/BRIEF.md
# Fail-First Vector Length Sequencer

This block walks the elements of a vector operation in index order and examines the result of each one as it arrives. For every element it derives a four-bit condition field from the result value and an overflow flag, applies a selectable test to that field, and issues write strobes for the result and for the condition field. The first active element that fails the test ends the walk. The block then reports a shortened vector length equal to the failing position. A configuration flag can make that length one larger, so that the failing element is also counted and written.

A run is launched by a `start` pulse. That pulse captures the requested length, the predicate mask and the test configuration. Results come in on a valid/ready stream, one beat per element index, masked-out indices included. `elem_ready` is high only while a run is active. A beat transfers on a clock edge where `elem_valid` and `elem_ready` are both high. A producer may hold `elem_valid` low for any number of cycles, which stalls the walk without loss. After the final or failing beat, `elem_ready` falls and the block accepts nothing more until the next run. Any beats still pending upstream belong to the producer.

Top module: `ff_vl_trunc`

## Requirements
- R1: After reset, `done` is 0, `elem_ready` is 0, `vl_out` is 0, and no write strobe is active.
- R2: A start with a requested length of 0 accepts no beats and raises `done` in the following cycle with `vl_out` = 0.
- R3: Beats are taken strictly in index order from 0. `wr_idx` names the index of the beat on the current handshake. Strobes occur only on a handshake cycle. Idle `elem_valid` cycles stall the walk. Requested lengths above MAXVL are clamped to MAXVL.
- R4: The condition field `cr_out` is {lt, gt, eq, so} in bits 3..0. lt is the sign bit of the result. eq is set for a zero result. gt is set when the result is neither negative nor zero. so is the overflow flag.
- R5: With both `rc_en` and `rc1_mode` low, an element passes when eq equals `zero_inv`. No condition-field strobe is issued.
- R6: With `rc_en` or `rc1_mode` high, `test_sel` picks the field bit (0 = lt, 1 = gt, 2 = eq, 3 = so). The element passes when that bit equals `test_val`. `cr_we` is pulsed for every active element examined, including a failing one.
- R7: On the first failing active element, the walk stops. `elem_ready` drops, no later index produces a strobe, and with `incl_fail` low `vl_out` equals the failing index and the failing result is not written.
- R8: With `incl_fail` high, the failing element's result is written and `vl_out` equals its index plus one.
- R9: With `rc1_mode` high, `res_we` never pulses. Condition fields are still written and tested.
- R10: A beat at an index whose mask bit is 0 is consumed without any strobe and can never fail.
- R11: If no active element fails, `vl_out` equals the (clamped) requested length.
- R12: `done` is a single-cycle pulse, and `vl_out` holds the new length in that cycle. A `start` during an active run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (ignored while one is active) |
| vl_in | input | VLW | Requested vector length |
| pred_mask | input | MAXVL | Per-element enable mask, bit i for index i |
| rc_en | input | 1 | Use the selectable condition test and write condition fields |
| rc1_mode | input | 1 | Test and write condition fields only, never results |
| test_sel | input | 2 | Field bit to test: 0 lt, 1 gt, 2 eq, 3 so |
| test_val | input | 1 | Value the selected bit must hold to pass |
| zero_inv | input | 1 | Default test sense: pass when eq equals this bit |
| incl_fail | input | 1 | Count and write the failing element |
| elem_valid | input | 1 | Result beat valid |
| elem_ready | output | 1 | Block accepts a beat this cycle |
| elem_data | input | DW | Element result |
| elem_ovf | input | 1 | Element overflow flag |
| res_we | output | 1 | Write strobe for the element result |
| cr_we | output | 1 | Write strobe for the element condition field |
| wr_idx | output | IW | Index of the current beat |
| cr_out | output | 4 | Condition field of the current beat |
| vl_out | output | VLW | Truncated vector length, valid with done |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with its defaults, MAXVL = 8 and DW = 16. With eight elements it is cheap to run full-length walks to the last index, to fail at index 0, and to fail in the middle. The sixteen-bit width makes negative, zero and positive results easy to write, so every condition-field bit and every test select can be exercised. Stalls on the stream and a start pulse issued mid-run are mixed into these runs.

// File: rtl/ff_pkg.sv
package ff_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_st_t;

  function automatic cond_t build_cond(input logic neg, input logic zero, input logic ovf);
    cond_t c;
    c.lt = neg;
    c.eq = zero;
    c.gt = !neg && !zero;
    c.so = ovf;
    return c;
  endfunction
endpackage

// File: rtl/ff_cond_eval.sv
module ff_cond_eval
  import ff_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] data,
  input  logic          ovf,
  input  logic          use_sel,
  input  logic [1:0]    sel,
  input  logic          want,
  input  logic          zinv,
  output cond_t         cond,
  output logic          pass
);
  logic pick;

  always_comb begin
    cond = build_cond(data[DW-1], data == '0, ovf);
    case (sel)
      2'd0:    pick = cond.lt;
      2'd1:    pick = cond.gt;
      2'd2:    pick = cond.eq;
      default: pick = cond.so;
    endcase
    pass = use_sel ? (pick == want) : (cond.eq == zinv);
  end
endmodule

// File: rtl/ff_seq_ctrl.sv
module ff_seq_ctrl
  import ff_pkg::*;
#(
  parameter int MAXVL = 8,
  localparam int IW  = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic           beat,
  input  logic           fail,
  input  logic           incl,
  output logic           running,
  output logic [IW-1:0]  idx,
  output logic [VLW-1:0] vl_cap,
  output logic [VLW-1:0] vl_out,
  output logic           done
);
  seq_st_t st;
  logic    last;
  logic [VLW-1:0] vl_clamp;

  assign running  = (st == ST_RUN);
  assign last     = (VLW'(idx) == vl_cap - VLW'(1));
  assign vl_clamp = (vl_in > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      vl_cap <= '0;
      vl_out <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            vl_cap <= vl_clamp;
            idx    <= '0;
            if (vl_clamp == '0) begin
              done   <= 1'b1;
              vl_out <= '0;
            end else begin
              st <= ST_RUN;
            end
          end
        end
        default: begin
          if (beat) begin
            if (fail) begin
              done   <= 1'b1;
              vl_out <= VLW'(idx) + VLW'(incl);
              st     <= ST_IDLE;
            end else if (last) begin
              done   <= 1'b1;
              vl_out <= vl_cap;
              st     <= ST_IDLE;
            end else begin
              idx <= idx + IW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ff_vl_trunc.sv
module ff_vl_trunc
  import ff_pkg::*;
#(
  parameter int MAXVL = 8,
  parameter int DW    = 16,
  localparam int IW  = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl_in,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic             rc_en,
  input  logic             rc1_mode,
  input  logic [1:0]       test_sel,
  input  logic             test_val,
  input  logic             zero_inv,
  input  logic             incl_fail,
  input  logic             elem_valid,
  output logic             elem_ready,
  input  logic [DW-1:0]    elem_data,
  input  logic             elem_ovf,
  output logic             res_we,
  output logic             cr_we,
  output logic [IW-1:0]    wr_idx,
  output logic [3:0]       cr_out,
  output logic [VLW-1:0]   vl_out,
  output logic             done
);
  logic [MAXVL-1:0] mask_q;
  logic       rc_q, rc1_q, val_q, zinv_q, incl_q;
  logic [1:0] sel_q;
  logic       running, beat, active, pass, fail_now;
  logic [IW-1:0]  idx;
  logic [VLW-1:0] vl_cap;
  cond_t      cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      rc_q   <= 1'b0;
      rc1_q  <= 1'b0;
      sel_q  <= '0;
      val_q  <= 1'b0;
      zinv_q <= 1'b0;
      incl_q <= 1'b0;
    end else if (start && !running) begin
      mask_q <= pred_mask;
      rc_q   <= rc_en;
      rc1_q  <= rc1_mode;
      sel_q  <= test_sel;
      val_q  <= test_val;
      zinv_q <= zero_inv;
      incl_q <= incl_fail;
    end
  end

  ff_seq_ctrl #(.MAXVL(MAXVL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
    .beat(beat), .fail(fail_now), .incl(incl_q),
    .running(running), .idx(idx), .vl_cap(vl_cap),
    .vl_out(vl_out), .done(done)
  );

  ff_cond_eval #(.DW(DW)) u_eval (
    .data(elem_data), .ovf(elem_ovf), .use_sel(rc_q | rc1_q),
    .sel(sel_q), .want(val_q), .zinv(zinv_q),
    .cond(cond), .pass(pass)
  );

  assign elem_ready = running;
  assign beat       = elem_valid && running;
  assign active     = mask_q[idx];
  assign fail_now   = active && !pass;
  assign res_we     = beat && active && !rc1_q && (pass || incl_q);
  assign cr_we      = beat && active && (rc_q || rc1_q);
  assign wr_idx     = idx;
  assign cr_out     = cond;
endmodule

// File: rtl/ff_vl_trunc_chk.sv
module ff_vl_trunc_chk #(
  parameter int VLW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           elem_valid,
  input logic           elem_ready,
  input logic           res_we,
  input logic           cr_we,
  input logic           done,
  input logic [VLW-1:0] vl_out,
  input logic [VLW-1:0] vl_cap,
  input logic           rc1_q,
  input logic           fail_now,
  input logic           active
);
  p_strobe_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we || cr_we) |-> (elem_valid && elem_ready));

  p_stop_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && elem_ready && fail_now) |=> (!elem_ready && done));

  p_rc1_nores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_ready && rc1_q) |-> !res_we);

  p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_ready && !active) |-> (!res_we && !cr_we));

  p_vl_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= vl_cap));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ff_vl_trunc ff_vl_trunc_chk #(.VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .elem_ready(elem_ready),
  .res_we(res_we), .cr_we(cr_we), .done(done), .vl_out(vl_out),
  .vl_cap(vl_cap), .rc1_q(rc1_q), .fail_now(fail_now), .active(active)
);

// File: tb/ff_vl_trunc_tb.sv
module ff_vl_trunc_tb;
  localparam int CLK_P = 10;
  localparam int MAXVL = 8;
  localparam int DW    = 16;
  localparam int IW    = 3;
  localparam int VLW   = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VLW-1:0] vl_in = '0;
  logic [MAXVL-1:0] pred_mask = '0;
  logic rc_en = 0, rc1_mode = 0, test_val = 0, zero_inv = 0, incl_fail = 0;
  logic [1:0] test_sel = '0;
  logic elem_valid = 0, elem_ovf = 0;
  logic [DW-1:0] elem_data = '0;
  logic elem_ready, res_we, cr_we, done;
  logic [IW-1:0] wr_idx;
  logic [3:0] cr_out;
  logic [VLW-1:0] vl_out;

  typedef struct packed {
    logic res;
    logic crw;
    logic [IW-1:0] idx;
    logic [3:0] cr;
  } wr_t;

  wr_t q[$];
  int errs = 0, checks = 0;
  string req = "R1";
  logic [DW-1:0] dat [MAXVL];
  logic ovf [MAXVL];

  always #(CLK_P/2) clk = ~clk;

  ff_vl_trunc #(.MAXVL(MAXVL), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .pred_mask(pred_mask),
    .rc_en(rc_en), .rc1_mode(rc1_mode), .test_sel(test_sel), .test_val(test_val),
    .zero_inv(zero_inv), .incl_fail(incl_fail), .elem_valid(elem_valid),
    .elem_ready(elem_ready), .elem_data(elem_data), .elem_ovf(elem_ovf),
    .res_we(res_we), .cr_we(cr_we), .wr_idx(wr_idx), .cr_out(cr_out),
    .vl_out(vl_out), .done(done)
  );

  task automatic chk(string r, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, got, exp);
    end
  endtask

  task automatic wrap_up();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    wrap_up();
  end

  // monitor: scoreboard of write strobes, sampled just before each rising edge
  always begin
    wr_t e;
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst_n && (res_we || cr_we)) begin
      if (q.size() == 0) chk(req, "unexpected write", 1, 0);
      else begin
        e = q.pop_front();
        chk(req, "write {res,cr,idx,field}", {res_we, cr_we, wr_idx, cr_out}, e);
      end
    end
  end

  task automatic fill();
    for (int i = 0; i < MAXVL; i++) begin
      dat[i] = DW'(i + 1);
      ovf[i] = 1'b0;
    end
  endtask

  task automatic run(string r, int vl, logic [MAXVL-1:0] m, logic rc, logic rc1,
                     logic [1:0] sel, logic val, logic zinv, logic incl,
                     int gap_every, bit poke);
    int exp_vl, i, cyc, lim;
    logic [3:0] c;
    logic bit_s, pass;
    req = r;
    lim = (vl > MAXVL) ? MAXVL : vl;
    exp_vl = lim;
    for (int k = 0; k < lim; k++) begin
      if (m[k]) begin
        c = {dat[k][DW-1], !dat[k][DW-1] && dat[k] != 0, dat[k] == 0, ovf[k]};
        bit_s = c[3 - sel];
        pass = (rc || rc1) ? (bit_s == val) : (c[1] == zinv);
        if ((!rc1 && (pass || incl)) || rc || rc1)
          q.push_back({!rc1 && (pass || incl), rc || rc1, IW'(k), c});
        if (!pass) begin
          exp_vl = k + (incl ? 1 : 0);
          break;
        end
      end
    end
    @(negedge clk);
    vl_in = VLW'(vl); pred_mask = m; rc_en = rc; rc1_mode = rc1;
    test_sel = sel; test_val = val; zero_inv = zinv; incl_fail = incl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    i = 0; cyc = 0;
    while (elem_ready) begin
      if (poke && cyc == 1) begin start = 1'b1; vl_in = VLW'(1); end
      else start = 1'b0;
      if (gap_every != 0 && (cyc % gap_every) == gap_every - 1) elem_valid = 1'b0;
      else begin
        elem_valid = 1'b1;
        elem_data = dat[i % MAXVL];
        elem_ovf = ovf[i % MAXVL];
        i++;
      end
      cyc++;
      @(negedge clk);
    end
    elem_valid = 1'b0; start = 1'b0;
    chk(r, "done after last beat", done, 1);
    chk(r, "vl_out", vl_out, exp_vl);
    chk(r, "pending writes left", q.size(), 0);
    q.delete();
    @(negedge clk);
    chk("R12", "done pulse width", done, 0);
    chk("R12", "vl_out held", vl_out, exp_vl);
  endtask

  initial begin
    fill();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done", done, 0);
    chk("R1", "elem_ready", elem_ready, 0);
    chk("R1", "vl_out", vl_out, 0);
    chk("R1", "strobes", {res_we, cr_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero length
    run("R2", 0, 8'hFF, 0, 0, 2'd0, 0, 0, 0, 0, 0);

    // R3 R5 R11: default test, no fail, stalls on the stream
    run("R11", 8, 8'hFF, 0, 0, 2'd0, 0, 0, 0, 3, 0);

    // R3: clamp length above MAXVL
    run("R3", 12, 8'hFF, 0, 0, 2'd0, 0, 0, 0, 0, 0);

    // R5 R7: zero result at index 3 fails, not included
    fill(); dat[3] = '0;
    run("R7", 8, 8'hFF, 0, 0, 2'd0, 0, 0, 0, 2, 0);

    // R8: failing element included
    run("R8", 8, 8'hFF, 0, 0, 2'd0, 0, 0, 1, 0, 0);

    // R5: inverted sense passes zeros, fails at first nonzero
    fill(); dat[0] = '0; dat[1] = '0;
    run("R5", 8, 8'hFF, 0, 0, 2'd0, 0, 1, 0, 0, 0);

    // R4 R6: ge test (lt must be 0), zero and overflow fields, negative at 5
    fill(); dat[1] = '0; ovf[3] = 1'b1; dat[5] = 16'hFFFD;
    run("R6", 8, 8'hFF, 1, 0, 2'd0, 0, 0, 0, 0, 0);

    // R4: gt test fails at index 0
    fill(); dat[0] = 16'h8000;
    run("R4", 8, 8'hFF, 1, 0, 2'd1, 1, 0, 0, 0, 0);

    // R9: condition-only mode, overflow test fails at 2 even when included
    fill(); ovf[2] = 1'b1;
    run("R9", 8, 8'hFF, 0, 1, 2'd3, 0, 0, 1, 0, 0);

    // R10: masked zero cannot fail
    fill(); dat[2] = '0;
    run("R10", 6, 8'b1111_1011, 0, 0, 2'd0, 0, 0, 0, 0, 0);

    // R12: start during a run is ignored
    fill();
    run("R12", 5, 8'hFF, 1, 0, 2'd2, 0, 0, 0, 2, 1);

    wrap_up();
  end
endmodule